// File: doc/BRIEF.md
# Serial Image Boot Loader

This block fills on-chip SRAM with a program image that arrives over a UART, one byte at a time, and then tells the processor where to start. When the chip leaves power-on reset, the loader sits in standby. It stays there until the wake pin rises from low to high. Whether the loader may run at all is decided by a boot-select input, which is sampled while reset is held. If that input selected the normal external boot, the loader stays idle until the next reset.

Once armed, the loader raises `rx_ready` toward the UART receiver. It turns every accepted byte into a single SRAM byte write. The write address comes from a byte counter that starts at zero. The image length is fixed by a parameter, 2048 bytes by default, which gives an 11-bit counter.

After the last byte is written, the loader does three things:
- It raises `done` and keeps it high.
- It emits a one-cycle `start_pulse`.
- It presents the SRAM start address on `start_addr`.

After that it refuses all further bytes and wake edges until reset.

Top module: `uart_boot_loader`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `rx_ready`, `mem_we`, `done` and `start_pulse` are 0, and `start_addr` always equals parameter `START_ADDR`.
- R2: After reset the loader stays in standby (`rx_ready` = 0) until `wake` is sampled low on one clock edge and high on the next. A `wake` level that is high at reset release does not start it. `rx_ready` becomes 1 in the cycle after the edge is sampled.
- R3: If `rom_boot_sel` was 0 on the last clock edge while `rst_n` was low, the loader never raises `rx_ready` or `mem_we`, whatever happens on `wake` and `rx_valid`.
- R4: While loading, a cycle with `rx_valid` = 1 and `rx_ready` = 1 drives `mem_we` = 1 and `mem_wdata` = `rx_data`. `mem_addr` equals the number of bytes accepted before, starting from 0, so byte k lands at address k.
- R5: A loading cycle with `rx_valid` = 0 gives `mem_we` = 0 and leaves `mem_addr` unchanged.
- R6: In the cycle after byte number `IMG_BYTES` is accepted, `done` = 1 and `start_pulse` = 1. `start_pulse` is 0 again in the following cycle.
- R7: Once `done` is 1 it stays 1 until reset. `rx_ready` and `mem_we` stay 0 even when `rx_valid` = 1.
- R8: A wake edge that arrives during a load neither restarts nor disturbs the byte address sequence.
- R9: Changes of `rom_boot_sel` after reset release have no effect on the loader.
- R10: A wake edge after `done` has no effect: `done` stays 1, `start_pulse` stays 0 and `rx_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, synchronous |
| rom_boot_sel | input | 1 | Boot-option select, sampled while reset is held (1 = serial boot) |
| wake | input | 1 | Wake pin, already synchronized to `clk`; a rising edge starts the load |
| rx_valid | input | 1 | Received byte is present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Loader accepts a byte this cycle |
| mem_we | output | 1 | SRAM byte write strobe |
| mem_addr | output | ADDR_W | SRAM byte address |
| mem_wdata | output | 8 | SRAM write data |
| done | output | 1 | Image fully written |
| start_pulse | output | 1 | One-cycle hand-off strobe to the processor |
| start_addr | output | 32 | Execution start address (start of SRAM) |

## Verification
The bench builds the loader with `IMG_BYTES` = 16 and a nonzero `START_ADDR`. The short image lets one run cover the whole path in a few hundred cycles: standby, the wake edge, the load, completion and the refusal that follows. It also puts the wrap of the counter after the final byte, and the last-byte detection, within easy reach. The nonzero start address shows that the hand-off address is driven and not merely left at zero. Two reset phases, one with the serial boot selected and one without, exercise the boot option that is latched during reset.

// File: rtl/uart_boot_loader.sv
module uart_boot_loader #(
  parameter int          IMG_BYTES  = 2048,
  parameter logic [31:0] START_ADDR = 32'h0000_0000,
  parameter int          ADDR_W     = $clog2(IMG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rom_boot_sel,
  input  logic              wake,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              done,
  output logic              start_pulse,
  output logic [31:0]       start_addr
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(IMG_BYTES - 1);

  typedef enum logic [1:0] {ST_STANDBY, ST_LOAD, ST_DONE} state_t;

  state_t            state;
  logic              rom_mode;
  logic              wake_q;
  logic [ADDR_W-1:0] cnt;
  logic              take;
  logic              wake_rise;

  always_ff @(posedge clk)
    if (!rst_n) rom_mode <= rom_boot_sel;

  assign rx_ready   = (state == ST_LOAD);
  assign take       = rx_valid && rx_ready;
  assign wake_rise  = wake && !wake_q;
  assign mem_we     = take;
  assign mem_addr   = cnt;
  assign mem_wdata  = rx_data;
  assign done       = (state == ST_DONE);
  assign start_addr = START_ADDR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_STANDBY;
      wake_q      <= 1'b1;
      cnt         <= '0;
      start_pulse <= 1'b0;
    end else begin
      wake_q      <= wake;
      start_pulse <= 1'b0;
      case (state)
        ST_STANDBY:
          if (rom_mode && wake_rise) state <= ST_LOAD;
        ST_LOAD:
          if (take) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              state       <= ST_DONE;
              start_pulse <= 1'b1;
            end
          end
        default: state <= ST_DONE;
      endcase
    end
  end

endmodule

// File: rtl/uart_boot_loader_chk.sv
module uart_boot_loader_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rom_mode,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              start_pulse
);

  p_no_rom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_mode |-> !rx_ready && !mem_we);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!rx_ready || mem_addr == $past(mem_addr) + 1'b1));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rx_valid) |=> $stable(mem_addr));

  p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  p_pulse_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $rose(done));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_done_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rx_ready && !mem_we);

  p_mode_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> $stable(rom_mode));

endmodule

bind uart_boot_loader uart_boot_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rom_mode(rom_mode), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .done(done), .start_pulse(start_pulse)
);

// File: tb/sim_uart_boot_loader.sv
`timescale 1ns/1ps
module sim_uart_boot_loader;
  localparam int          N  = 16;
  localparam int          AW = $clog2(N);
  localparam logic [31:0] SA = 32'h1000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rom_boot_sel = 1'b1;
  logic          wake = 1'b1;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = 8'h00;
  logic          rx_ready, mem_we, done, start_pulse;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [31:0]   start_addr;
  logic [7:0]    mem [N];
  int            n_chk = 0;
  int            n_fail = 0;

  always #10 clk = ~clk;

  uart_boot_loader #(.IMG_BYTES(N), .START_ADDR(SA)) u0 (
    .clk(clk), .rst_n(rst_n), .rom_boot_sel(rom_boot_sel), .wake(wake),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .start_pulse(start_pulse), .start_addr(start_addr));

  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic sel);
    @(negedge clk);
    rst_n = 1'b0; rom_boot_sel = sel; wake = 1'b1; rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rx_ready && !mem_we && !done && !start_pulse, "R1 outputs in reset",
        {rx_ready, mem_we, done, start_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rx_ready && !mem_we && !done && !start_pulse, "R1 outputs after reset",
        {rx_ready, mem_we, done, start_pulse}, 0);
    chk(start_addr == SA, "R1 start_addr", start_addr, SA);
  endtask

  task automatic wake_edge();
    wake = 1'b0;
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input int exp_addr);
    rx_valid = 1'b1; rx_data = d;
    #1;
    chk(mem_we == 1'b1, "R4 write strobe", mem_we, 1);
    chk(mem_addr == AW'(exp_addr), "R4 address", mem_addr, exp_addr);
    chk(mem_wdata == d, "R4 write data", mem_wdata, d);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_standby();
    do_reset(1'b1);
    repeat (5) @(negedge clk);
    chk(rx_ready == 1'b0, "R2 held wake does not start", rx_ready, 0);
    rom_boot_sel = 1'b0;
    wake = 1'b0;
    @(negedge clk);
    wake = 1'b1;
    #1;
    chk(rx_ready == 1'b0, "R2 not ready before edge sampled", rx_ready, 0);
    @(negedge clk);
    chk(rx_ready == 1'b1, "R2/R9 ready after wake edge", rx_ready, 1);
  endtask

  task automatic t_load();
    for (int i = 0; i < N; i++) begin
      if (i % 3 == 1) begin
        logic [AW-1:0] a0;
        a0 = mem_addr;
        #1;
        chk(mem_we == 1'b0, "R5 no write when idle", mem_we, 0);
        @(negedge clk);
        chk(mem_addr == a0 && rx_ready, "R5 address held", mem_addr, a0);
      end
      if (i == 8) begin
        wake_edge();
        chk(rx_ready == 1'b1 && mem_addr == AW'(8), "R8 wake during load ignored", mem_addr, 8);
      end
      send_byte(8'(8'hA5 ^ (i * 37)), i);
      if (i < N - 1)
        chk(done == 1'b0 && start_pulse == 1'b0, "R6 not done early", done, 0);
    end
    chk(done == 1'b1, "R6 done after last byte", done, 1);
    chk(start_pulse == 1'b1, "R6 start pulse", start_pulse, 1);
    @(negedge clk);
    chk(start_pulse == 1'b0, "R6 pulse one cycle", start_pulse, 0);
    for (int i = 0; i < N; i++)
      chk(mem[i] == 8'(8'hA5 ^ (i * 37)), "R4 image content", mem[i], 8'(8'hA5 ^ (i * 37)));
  endtask

  task automatic t_after_done();
    rx_valid = 1'b1; rx_data = 8'h3C;
    #1;
    chk(!mem_we && !rx_ready, "R7 bytes refused after done", {mem_we, rx_ready}, 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && !mem_we, "R7 done sticky", {done, mem_we}, 2);
    rx_valid = 1'b0;
    chk(mem[0] == 8'hA5, "R7 memory untouched", mem[0], 8'hA5);
    wake_edge();
    @(negedge clk);
    chk(done && !start_pulse && !rx_ready, "R10 wake after done ignored",
        {done, start_pulse, rx_ready}, 4);
  endtask

  task automatic t_no_rom();
    do_reset(1'b0);
    rom_boot_sel = 1'b1;
    wake_edge();
    @(negedge clk);
    chk(rx_ready == 1'b0, "R3 no load without serial boot", rx_ready, 0);
    rx_valid = 1'b1;
    #1;
    chk(mem_we == 1'b0, "R3 no write without serial boot", mem_we, 0);
    @(negedge clk);
    rx_valid = 1'b0;
    chk(done == 1'b0, "R3 never done", done, 0);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_standby();
    t_load();
    t_after_done();
    t_no_rom();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule